// File: doc/BRIEF.md
# External Edge and Port-Change Interrupt Detector

This block watches two sets of asynchronous input pins and turns activity on them into interrupt flags for an interrupt controller. Three dedicated request pins each own an edge detector, a polarity select and a sticky flag, and they never affect one another. Four further port pins form one shared source: its single flag rises whenever the synchronized level of any of those pins differs from a reference copy, whether the pin went up or down.

Every pin first passes through a two-stage synchronizer. Each detected edge or new mismatch gives a one-cycle event pulse next to the sticky flag. A small register port lets software pick the polarities, clear flags by writing ones, and read the port pins. The port read also loads the reference copy, and that is the only way a group mismatch goes away. All pins are plain level or strobe signals. No data stream crosses the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset all flags and event pulses are 0, reg_rdata is 0, every polarity select is 0 (rising edge) and the group reference copy is 0000.
- R2: With select bit i = 0, a 0-to-1 change on ext_pin[i] sets ext_flag[i] and pulses ext_event[i] for exactly one cycle; both appear after the third rising clock edge that follows the change. A 1-to-0 change does nothing.
- R3: With select bit i = 1 (address 0, bit i), a 1-to-0 change on ext_pin[i] triggers with the same timing, and a 0-to-1 change does nothing.
- R4: A flag stays set until a write to address 1 with a 1 in its bit (bit i for ext_flag[i], bit 3 for grp_flag). If a clear and a new event meet on the same edge, the flag stays set.
- R5: An edge on one dedicated pin changes only that pin's flag and event.
- R6: Writing a new polarity select while the pin is steady raises no flag and no event.
- R7: When any grp_pin differs from the reference copy, whether it went up or down, grp_flag sets and grp_event pulses once, with the same three-edge timing as R2.
- R8: A read of address 2 returns the synchronized group pins in bits 3:0 of reg_rdata after the edge that samples reg_rd. The same edge loads the reference copy, so a later clear of bit 3 takes effect and lasts.
- R9: While the mismatch persists, a clear of grp_flag has no effect.
- R10: A read of address 0 returns the selects in bits 2:0, address 1 returns {grp_flag, ext_flag} in bits 3:0, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | Dedicated asynchronous request pins |
| grp_pin | input | 4 | Asynchronous port pins of the shared change source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 select, 1 flags, 2 port, 3 reserved) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered on a read strobe |
| ext_event | output | 3 | One-cycle pulse per detected edge |
| ext_flag | output | 3 | Sticky dedicated-pin flags |
| grp_event | output | 1 | One-cycle pulse when a group mismatch begins |
| grp_flag | output | 1 | Sticky group change flag |

## Verification
A pin change made just after clock edge n shows on its flag and event after edge n+3. Read data and the reference load appear after the edge that samples the strobe, and a write-one clear acts on the next edge. The bench drives and samples 1 ns after each rising edge. It checks every expected result in exactly its due cycle, and also checks the cycles just before it, so that an early or late flag is caught. During the random phase a per-slot history of pin values and clears gives the expected event and flag after every edge.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int REG_AW = 2;
  typedef enum logic [REG_AW-1:0] {
    A_SEL  = 2'd0,
    A_FLAG = 2'd1,
    A_PORT = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_irq_edge_chan.sv
module pin_irq_edge_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic fall_sel,
  input  logic clr,
  output logic evt,
  output logic flag
);
  logic lvl_q;
  logic hit;

  // polarity picks which transition counts; it never mixes into the level
  assign hit = fall_sel ? (lvl_q & ~lvl) : (~lvl_q & lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      evt   <= 1'b0;
      flag  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      evt   <= hit;
      flag  <= hit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/pin_irq_group.sv
module pin_irq_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         snap,
  input  logic         clr,
  output logic         evt,
  output logic         flag
);
  logic [W-1:0] ref_q;
  logic         mism;
  logic         mism_q;

  assign mism = |(lvl ^ ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      mism_q <= 1'b0;
      evt    <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (snap) ref_q <= lvl;
      mism_q <= mism;
      evt    <= mism & ~mism_q;
      flag   <= mism | (flag & ~clr);
    end
  end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int N_GRP = 4,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [N_EXT-1:0]  ext_flag,
  input  logic              grp_flag,
  input  logic [N_GRP-1:0]  grp_lvl,
  output logic [N_EXT-1:0]  fall_sel,
  output logic [N_EXT-1:0]  ext_clr,
  output logic              grp_clr,
  output logic              port_snap,
  output logic [DW-1:0]     reg_rdata
);
  localparam int FLAG_W = N_EXT + 1;

  logic          wr_flag;
  logic [DW-1:0] rd_mux;
  logic          wdata_unused;

  assign wdata_unused = ^reg_wdata[DW-1:FLAG_W];
  assign wr_flag   = reg_wr && (reg_addr == A_FLAG);
  assign ext_clr   = wr_flag ? reg_wdata[N_EXT-1:0] : '0;
  assign grp_clr   = wr_flag & reg_wdata[N_EXT];
  assign port_snap = reg_rd && (reg_addr == A_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_sel <= '0;
    else if (reg_wr && (reg_addr == A_SEL)) fall_sel <= reg_wdata[N_EXT-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_SEL:   rd_mux[N_EXT-1:0]  = fall_sel;
      A_FLAG:  rd_mux[FLAG_W-1:0] = {grp_flag, ext_flag};
      A_PORT:  rd_mux[N_GRP-1:0]  = grp_lvl;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int N_EXT  = 3,
  parameter int N_GRP  = 4,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_GRP-1:0]  grp_pin,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [N_EXT-1:0]  ext_event,
  output logic [N_EXT-1:0]  ext_flag,
  output logic              grp_event,
  output logic              grp_flag
);
  localparam int NPIN = N_EXT + N_GRP;

  logic [NPIN-1:0]  pin_s;
  logic [N_EXT-1:0] fall_sel;
  logic [N_EXT-1:0] ext_clr;
  logic             grp_clr;
  logic             port_snap;

  pin_irq_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({grp_pin, ext_pin}), .q(pin_s)
  );

  for (genvar i = 0; i < N_EXT; i++) begin : g_chan
    pin_irq_edge_chan u_chan (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s[i]), .fall_sel(fall_sel[i]),
      .clr(ext_clr[i]), .evt(ext_event[i]), .flag(ext_flag[i])
    );
  end

  pin_irq_group #(.W(N_GRP)) u_grp (
    .clk(clk), .rst_n(rst_n), .lvl(pin_s[N_EXT +: N_GRP]), .snap(port_snap),
    .clr(grp_clr), .evt(grp_event), .flag(grp_flag)
  );

  pin_irq_regs #(.N_EXT(N_EXT), .N_GRP(N_GRP), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ext_flag(ext_flag),
    .grp_flag(grp_flag), .grp_lvl(pin_s[N_EXT +: N_GRP]), .fall_sel(fall_sel),
    .ext_clr(ext_clr), .grp_clr(grp_clr), .port_snap(port_snap),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int N_EXT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [N_EXT:0]   clr_bits,
  input logic [N_EXT-1:0] ext_event,
  input logic [N_EXT-1:0] ext_flag,
  input logic             grp_event,
  input logic             grp_flag
);
  logic wr_flag;
  assign wr_flag = reg_wr && (reg_addr == 2'd1);

  for (genvar i = 0; i < N_EXT; i++) begin : g_p
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flag[i] && !(wr_flag && clr_bits[i])) |=> ext_flag[i]);
    p_event_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_event[i] |=> !ext_event[i]);
    p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_event[i] |-> ext_flag[i]);
    p_flag_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_flag[i]) |-> ext_event[i]);
  end

  p_grp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_event |=> !grp_event);
  p_grp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_flag && !(wr_flag && clr_bits[N_EXT])) |=> grp_flag);
  p_grp_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_flag) |-> grp_event);
endmodule

bind pin_irq_detect pin_irq_chk #(.N_EXT(N_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .clr_bits(reg_wdata[N_EXT:0]), .ext_event(ext_event), .ext_flag(ext_flag),
  .grp_event(grp_event), .grp_flag(grp_flag)
);

// File: tb/tb_pin_irq_detect.sv
`timescale 1ns/1ps
module tb_pin_irq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ext_pin = '0;
  logic [3:0] grp_pin = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] ext_event, ext_flag;
  logic       grp_event, grp_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .grp_pin(grp_pin),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_event(ext_event), .ext_flag(ext_flag),
    .grp_event(grp_event), .grp_flag(grp_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
  endtask

  function automatic logic edge_hit(input logic a, input logic b, input logic fall);
    return fall ? (a & ~b) : (~a & b);
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  logic [2:0] eh   [0:43];
  logic [2:0] ch   [0:43];

  initial begin
    logic [2:0] pv, sel, ef, ev;
    void'($urandom(32'h5eed));
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 flags", {grp_flag, ext_flag}, 4'h0);
    chk("R1 events", {grp_event, ext_event}, 4'h0);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(2'd0);
    chk("R1 select default", reg_rdata, 8'h00);

    // R2 rising edge on pin 0
    ext_pin[0] = 1'b1;
    tick(2);
    chk("R2 not early", ext_flag, 3'b000);
    tick();
    chk("R2 flag", ext_flag, 3'b001);
    chk("R2/R5 event", ext_event, 3'b001);
    tick();
    chk("R2 pulse one cycle", ext_event, 3'b000);
    chk("R4 sticky", ext_flag, 3'b001);
    wr(2'd1, 8'h07);
    chk("R4 clear", ext_flag, 3'b000);
    ext_pin[0] = 1'b0;
    tick(5);
    chk("R2 falling ignored", ext_flag, 3'b000);

    // R6 select change with steady pins
    ext_pin[1] = 1'b1;
    tick(5);
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h03);
    tick(4);
    wr(2'd0, 8'h01);
    tick(4);
    chk("R6 no spurious flag", ext_flag, 3'b000);
    chk("R6 no spurious event", ext_event, 3'b000);
    rd(2'd0);
    chk("R10 select readback", reg_rdata, 8'h01);

    // R3 falling select on pin 0
    ext_pin[0] = 1'b1;
    tick(5);
    chk("R3 rising ignored", ext_flag, 3'b000);
    ext_pin[0] = 1'b0;
    tick(3);
    chk("R3 falling triggers", ext_flag, 3'b001);
    chk("R3 event", ext_event, 3'b001);
    wr(2'd1, 8'h01);

    // R4 clear meeting a new event
    ext_pin[2] = 1'b1;
    tick(3);
    chk("R4 pin2 flag", ext_flag, 3'b100);
    ext_pin[2] = 1'b0;
    tick(3);
    ext_pin[2] = 1'b1;
    tick(2);
    wr(2'd1, 8'h04);
    chk("R4 set beats clear", ext_flag, 3'b100);
    rd(2'd1);
    chk("R10 flag readback", reg_rdata, 8'h04);
    wr(2'd1, 8'h04);
    chk("R4 clear after", ext_flag, 3'b000);
    rd(2'd3);
    chk("R10 reserved", reg_rdata, 8'h00);

    // R7 group change low-to-high
    grp_pin = 4'b0100;
    tick(2);
    chk("R7 not early", grp_flag, 1'b0);
    tick();
    chk("R7 flag", grp_flag, 1'b1);
    chk("R7 event", grp_event, 1'b1);
    tick();
    chk("R7 pulse one cycle", grp_event, 1'b0);
    wr(2'd1, 8'h08);
    tick();
    chk("R9 clear ignored while mismatch", grp_flag, 1'b1);
    rd(2'd2);
    chk("R8 port read", reg_rdata, 8'h04);
    wr(2'd1, 8'h08);
    chk("R8 clear takes", grp_flag, 1'b0);
    tick(4);
    chk("R8 stays clear", grp_flag, 1'b0);
    grp_pin = 4'b0000;
    tick(3);
    chk("R7 high-to-low", grp_flag, 1'b1);
    rd(2'd2);
    chk("R8 port read zero", reg_rdata, 8'h00);
    wr(2'd1, 8'h08);
    chk("R8 clear", grp_flag, 1'b0);

    // random phase on dedicated pins
    pv = ext_pin;
    for (int seg = 0; seg < 8; seg++) begin
      sel = 3'($urandom);
      wr(2'd1, 8'h07);
      wr(2'd0, {5'd0, sel});
      tick(4);
      chk("R6 random select", ext_flag, 3'b000);
      for (int n = 0; n < 44; n++) begin
        eh[n] = (n < 36) ? 3'($urandom) : eh[35];
        ch[n] = (n < 36 && ($urandom % 4 == 0)) ? 3'($urandom) : 3'b000;
      end
      ef = 3'b000;
      for (int n = 0; n < 44; n++) begin
        int c;
        logic [2:0] a, b;
        ext_pin = eh[n];
        reg_wr = (ch[n] != 0); reg_addr = 2'd1; reg_wdata = {5'd0, ch[n]};
        tick();
        reg_wr = 1'b0;
        c = n + 1;
        a = (c - 4 < 0) ? pv : eh[c-4];
        b = (c - 3 < 0) ? pv : eh[c-3];
        for (int i = 0; i < 3; i++) ev[i] = edge_hit(a[i], b[i], sel[i]);
        ef = ev | (ef & ~ch[n]);
        chk("R2/R3/R5 random event", ext_event, ev);
        chk("R4 random flag", ext_flag, ef);
      end
      pv = eh[43];
    end
    finish_up();
  end
endmodule